// File: doc/BRIEF.md
# Programmable Six-Mode Down-Counter Channel

A single 16-bit down-counting timer channel. It runs on the block clock, takes a gate input, and drives one waveform output. Software first writes a mode selection with a binary/BCD choice, and then writes an initial count as bytes. Counting then follows one of six behaviours: a level change on terminal count, a retriggerable one-shot, a rate generator, a square wave, a strobe started by software and a strobe started by the gate.

A count of zero stands for the full range: 65536 clocks in binary and 10000 clocks in BCD. The current counter value is always visible on `count_o`. A system uses one instance for each timer channel, and decodes any addresses outside the block.

Top module: `tmr_channel`

## Requirements
- R1: After reset `out_o` is 1 and `count_o` is 0.
- R2: A mode write (`cfg_we_i`) sets `out_o` to 0 on the next clock when the mode code is 0, and to 1 for codes 1 to 5. It does not change `count_o`. Codes 6 and 7 behave as codes 2 and 3. A mode write restarts the byte order of the count, so the next byte written is the low byte.
- R3: The initial count is written as two bytes on `cnt_byte_i` with `cnt_we_i`, low byte first. In modes 0, 2 and 4, `count_o` keeps its old value in the cycle after the high-byte write, and shows the new count one clock later.
- R4: With `cfg_bcd_i`=0 the counter steps down by one in binary and wraps from 0 to FFFFh. With `cfg_bcd_i`=1 every 4-bit digit stays in the range 0 to 9, a borrow passes between digits (0010h becomes 0009h), and 0 wraps to 9999h.
- R5: Mode 0: `out_o` is low from the mode write onwards. It stays low for N+1 clocks counted from the high-byte write, then goes high and stays high.
- R6: Mode 1: a rising gate edge drives `out_o` low for N clocks. A new rising edge during the pulse restarts the N-clock low time.
- R7: Mode 2: `out_o` repeats with period N, high for N-1 clocks and low for 1 clock. N must be at least 2.
- R8: Mode 3: `out_o` is a square wave. It is high for ceil(N/2) clocks and low for floor(N/2) clocks. N must be at least 2.
- R9: Mode 4: after the load, `out_o` stays high for N clocks, then goes low for exactly one clock. It does this once per load.
- R10: Mode 5: a rising gate edge starts the same N-high, one-low strobe as mode 4. A new rising edge before the strobe restarts the N-clock wait.
- R11: A low gate holds `count_o` in modes 0 and 4. In modes 2 and 3 a low gate forces `out_o` high and returns the counter to the start of a period. Counting restarts when the gate goes high again.
- R12: A loaded count of 0 gives 65536 counting clocks in binary and 10000 in BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Mode write strobe |
| cfg_mode_i | input | 3 | Mode code 0..7 |
| cfg_bcd_i | input | 1 | 1 selects BCD counting |
| cnt_we_i | input | 1 | Count byte write strobe |
| cnt_byte_i | input | 8 | Count byte, low byte first |
| gate_i | input | 1 | Gate: enables counting or triggers it, depending on mode |
| out_o | output | 1 | Waveform output |
| count_o | output | 16 | Current counter value |

## Verification
Random passes pick one of modes 0, 2, 3 and 4, pick binary or BCD, and pick a count between 2 and 200. Each pass measures the high and low run lengths against formulas for that mode. Odd and even counts in mode 3 tell a correct half-period split from a plain halving. Directed cases cover the rest:
- zero counts in both number formats, which tell the full-range rule apart from an off-by-one wrap;
- the BCD borrow from 0010h, which a binary decrement would turn into 000Fh;
- gate retriggers in modes 1 and 5;
- gate-low holds and restarts;
- the folded mode codes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } tmr_mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic tmr_mode_e fold_mode(logic [2:0] m);
    if (m[2:1] == 2'b11) return tmr_mode_e'({1'b0, m[1:0]});
    return tmr_mode_e'(m);
  endfunction
endpackage

// File: rtl/tmr_step.sv
module tmr_step #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] val_i,
  input  logic             bcd_i,
  input  logic             two_i,
  output logic [CNT_W-1:0] res_o
);
  localparam int ND = CNT_W / 4;

  logic [ND-1:0]    bw;
  logic [CNT_W-1:0] bcd_res;
  logic [CNT_W-1:0] bin_res;

  assign bw[0] = 1'b0;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [4:0] sub;
    logic [4:0] diff;
    assign sub  = (i == 0) ? (two_i ? 5'd2 : 5'd1) : 5'd0;
    assign diff = {1'b0, val_i[4*i +: 4]} - sub - {4'd0, bw[i]};
    assign bcd_res[4*i +: 4] = diff[4] ? (diff[3:0] + 4'd10) : diff[3:0];
    if (i < ND - 1) begin : g_bw
      assign bw[i+1] = diff[4];
    end
  end

  assign bin_res = val_i - (two_i ? CNT_W'(2) : CNT_W'(1));
  assign res_o   = bcd_i ? bcd_res : bin_res;
endmodule

// File: rtl/tmr_incr.sv
module tmr_incr #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] val_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] res_o
);
  localparam int ND = CNT_W / 4;

  logic [ND-1:0]    cy;
  logic [CNT_W-1:0] bcd_res;

  assign cy[0] = 1'b1;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [4:0] sum;
    assign sum = {1'b0, val_i[4*i +: 4]} + {4'd0, cy[i]};
    assign bcd_res[4*i +: 4] = (sum == 5'd10) ? 4'd0 : sum[3:0];
    if (i < ND - 1) begin : g_cy
      assign cy[i+1] = (sum == 5'd10);
    end
  end

  assign res_o = bcd_i ? bcd_res : (val_i + CNT_W'(1));
endmodule

// File: rtl/tmr_load_regs.sv
module tmr_load_regs #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              lo_wr_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  reload_o
);
  localparam int NB = CNT_W / BYTE_W;
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;

  logic [PW-1:0]    ptr_q;
  logic [CNT_W-1:0] hold_q;
  logic             load_q;
  logic             wr;
  logic             last;

  assign wr      = we_i && !cfg_we_i;
  assign last    = (ptr_q == PW'(NB - 1));
  assign lo_wr_o = wr && (ptr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      load_q <= 1'b0;
      hold_q <= '0;
    end else begin
      load_q <= wr && last;
      if (cfg_we_i) ptr_q <= '0;
      else if (wr) ptr_q <= last ? '0 : ptr_q + PW'(1);
      if (wr) begin
        for (int b = 0; b < NB; b++) begin
          if (ptr_q == PW'(b)) hold_q[b*BYTE_W +: BYTE_W] <= byte_i;
        end
      end
    end
  end

  assign load_o   = load_q;
  assign reload_o = hold_q;
endmodule

// File: rtl/tmr_wave_ctrl.sv
module tmr_wave_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  tmr_mode_e        cfg_mode_i,
  input  logic             cfg_bcd_i,
  input  logic             lo_wr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] hi_val_i,
  input  logic [CNT_W-1:0] lo_val_i,
  input  logic             gate_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out_o,
  output tmr_mode_e        mode_o,
  output logic             bcd_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  tmr_mode_e        mode_q;
  logic             bcd_q, armed_q, run_q, out_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dec_zero;

  assign dec_zero = (dec_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_TERM;
      bcd_q   <= 1'b0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      out_q   <= 1'b1;
      cnt_q   <= '0;
    end else if (cfg_we_i) begin
      mode_q  <= cfg_mode_i;
      bcd_q   <= cfg_bcd_i;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      out_q   <= (cfg_mode_i != M_TERM);
    end else if (load_i) begin
      armed_q <= 1'b1;
      case (mode_q)
        M_TERM: begin
          cnt_q <= reload_i;
          run_q <= 1'b1;
          out_q <= 1'b0;
        end
        M_RATE, M_SWSTB: begin
          cnt_q <= reload_i;
          run_q <= 1'b1;
          out_q <= 1'b1;
        end
        M_SQUARE: begin
          cnt_q <= hi_val_i;
          out_q <= 1'b1;
        end
        default: ;  // gate-started modes wait for a trigger
      endcase
    end else begin
      if (armed_q) begin
        case (mode_q)
          M_TERM, M_SWSTB: begin
            if (mode_q == M_SWSTB && !out_q) out_q <= 1'b1;
            if (gate_i) begin
              cnt_q <= dec_i;
              if (run_q && dec_zero) begin
                run_q <= 1'b0;
                out_q <= (mode_q == M_TERM);
              end
            end
          end
          M_ONESHOT, M_HWSTB: begin
            if (mode_q == M_HWSTB && !out_q) out_q <= 1'b1;
            if (trig_i) begin
              cnt_q <= reload_i;
              run_q <= 1'b1;
              out_q <= (mode_q == M_HWSTB);
            end else if (run_q) begin
              cnt_q <= dec_i;
              if (dec_zero) begin
                run_q <= 1'b0;
                out_q <= (mode_q == M_ONESHOT);
              end
            end
          end
          M_RATE: begin
            if (!gate_i || cnt_q == ONE) begin
              cnt_q <= reload_i;
              out_q <= 1'b1;
            end else begin
              cnt_q <= dec_i;
              if (dec_i == ONE) out_q <= 1'b0;
            end
          end
          M_SQUARE: begin
            if (!gate_i) begin
              cnt_q <= hi_val_i;
              out_q <= 1'b1;
            end else if (cnt_q == TWO) begin
              out_q <= !out_q;
              cnt_q <= out_q ? lo_val_i : hi_val_i;
            end else begin
              cnt_q <= dec_i;
            end
          end
          default: ;
        endcase
      end
      // a fresh low byte in mode 0 drops the output at once
      if (lo_wr_i && mode_q == M_TERM) begin
        out_q <= 1'b0;
        run_q <= 1'b0;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign out_o   = out_q;
  assign mode_o  = mode_q;
  assign bcd_o   = bcd_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_mode_i,
  input  logic              cfg_bcd_i,
  input  logic              cnt_we_i,
  input  logic [BYTE_W-1:0] cnt_byte_i,
  input  logic              gate_i,
  output logic              out_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             gate_q, trig_w;
  logic             lo_wr_w, load_w, bcd_w, armed_w;
  logic [CNT_W-1:0] reload_w, reload_dn_w, reload_up_w;
  logic [CNT_W-1:0] hi_val_w, lo_val_w, cnt_w, dec_w;
  tmr_mode_e        mode_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate_i;
  end
  assign trig_w = gate_i && !gate_q;

  tmr_load_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we_i),
    .we_i     (cnt_we_i),
    .byte_i   (cnt_byte_i),
    .lo_wr_o  (lo_wr_w),
    .load_o   (load_w),
    .reload_o (reload_w)
  );

  tmr_step #(.CNT_W(CNT_W)) u_cnt_step (
    .val_i (cnt_w),
    .bcd_i (bcd_w),
    .two_i (mode_w == M_SQUARE),
    .res_o (dec_w)
  );

  tmr_step #(.CNT_W(CNT_W)) u_rel_dn (
    .val_i (reload_w),
    .bcd_i (bcd_w),
    .two_i (1'b0),
    .res_o (reload_dn_w)
  );

  tmr_incr #(.CNT_W(CNT_W)) u_rel_up (
    .val_i (reload_w),
    .bcd_i (bcd_w),
    .res_o (reload_up_w)
  );

  // odd counts: one extra clock in the high half
  assign hi_val_w = reload_w[0] ? reload_up_w : reload_w;
  assign lo_val_w = reload_w[0] ? reload_dn_w : reload_w;

  tmr_wave_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_mode_i (fold_mode(cfg_mode_i)),
    .cfg_bcd_i  (cfg_bcd_i),
    .lo_wr_i    (lo_wr_w),
    .load_i     (load_w),
    .reload_i   (reload_w),
    .hi_val_i   (hi_val_w),
    .lo_val_i   (lo_val_w),
    .gate_i     (gate_i),
    .trig_i     (trig_w),
    .dec_i      (dec_w),
    .cnt_o      (cnt_w),
    .out_o      (out_o),
    .mode_o     (mode_w),
    .bcd_o      (bcd_w),
    .armed_o    (armed_w)
  );

  assign count_o = cnt_w;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             gate_i,
  input logic             out_o,
  input logic             load_i,
  input logic             armed_i,
  input logic             bcd_i,
  input tmr_mode_e        mode_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] reload_i
);
  localparam int ND = CNT_W / 4;

  function automatic logic digits_ok(logic [CNT_W-1:0] v);
    for (int i = 0; i < ND; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  assert_mode_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (out_o == (mode_i != M_TERM)));

  assert_load_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !cfg_we_i && (mode_i inside {M_TERM, M_RATE, M_SWSTB}))
    |=> count_o == $past(reload_i));

  assert_bcd_digits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcd_i && armed_i && (mode_i inside {M_TERM, M_RATE, M_SQUARE, M_SWSTB}))
    |-> digits_ok(count_o));

  assert_oneshot_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_ONESHOT && armed_i && $rose(gate_i) && !cfg_we_i && !load_i)
    |=> !out_o);

  assert_rate_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_RATE && armed_i && !out_o && !cfg_we_i) |=> out_o);

  // covers the strobe of R10 as well
  assert_strobe_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i inside {M_SWSTB, M_HWSTB}) && !out_o && !cfg_we_i) |=> out_o);

  assert_gate_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i inside {M_TERM, M_SWSTB}) && armed_i && !gate_i && !cfg_we_i && !load_i)
    |=> $stable(count_o));

  assert_gate_force_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i inside {M_RATE, M_SQUARE}) && armed_i && !gate_i && !cfg_we_i)
    |=> out_o);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .gate_i   (gate_i),
  .out_o    (out_o),
  .load_i   (load_w),
  .armed_i  (armed_w),
  .bcd_i    (bcd_w),
  .mode_i   (mode_w),
  .count_o  (count_o),
  .reload_i (reload_w)
);

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic        cfg_bcd = 1'b0;
  logic        cnt_we = 1'b0;
  logic [7:0]  cnt_byte = 8'd0;
  logic        gate = 1'b0;
  logic        out;
  logic [15:0] count;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tmr_channel dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_mode_i (cfg_mode),
    .cfg_bcd_i  (cfg_bcd),
    .cnt_we_i   (cnt_we),
    .cnt_byte_i (cnt_byte),
    .gate_i     (gate),
    .out_o      (out),
    .count_o    (count)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int exp_hi(input int m, input int n);
    if (m == 3) return (n + 1) / 2;
    if (m == 2) return n - 1;
    return n;
  endfunction

  function automatic int exp_lo(input int m, input int n);
    if (m == 3) return n / 2;
    if (m == 0) return n + 1;
    return 1;
  endfunction

  task automatic cfg(input logic [2:0] m, input logic b);
    cfg_mode = m; cfg_bcd = b; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    cnt_we = 1'b1; cnt_byte = v[7:0];
    @(negedge clk);
    cnt_byte = v[15:8];
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (out === lvl && n < 70000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic lows_in(input int k, output int n);
    n = 0;
    for (int i = 0; i < k; i++) begin
      if (out === 1'b0) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual 190000 cycles expected completion earlier");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out", int'(out), 1);
    check("R1 count", int'(count), 0);

    cfg(3'd0, 1'b0);
    check("R2 mode0 out low", int'(out), 0);
    check("R2 count kept", int'(count), 0);

    // stray low byte then mode write: byte order restarts (R2), load timing (R3)
    gate = 1'b0;
    cnt_we = 1'b1; cnt_byte = 8'hAA;
    @(negedge clk);
    cnt_we = 1'b0;
    cfg(3'd4, 1'b0);
    check("R2 mode4 out high", int'(out), 1);
    load(16'h1234);
    check("R3 count before load", int'(count), 0);
    @(negedge clk);
    check("R3 count loaded", int'(count), 16'h1234);
    @(negedge clk);
    check("R11 mode4 gate low hold", int'(count), 16'h1234);
    gate = 1'b1;
    @(negedge clk);
    check("R4 binary step", int'(count), 16'h1233);

    // R11 mode 0 gate suspend
    gate = 1'b0;
    cfg(3'd0, 1'b0);
    load(16'd5);
    repeat (4) @(negedge clk);
    check("R11 mode0 hold count", int'(count), 5);
    check("R11 mode0 out low", int'(out), 0);
    gate = 1'b1;
    run_len(1'b0, a);
    check("R5/R11 resumed low length", a, 5);

    // R4 BCD borrow and wrap
    cfg(3'd0, 1'b1);
    load(16'h0010);
    @(negedge clk);
    check("R4 bcd loaded", int'(count), 16'h0010);
    @(negedge clk);
    check("R4 bcd borrow", int'(count), 16'h0009);
    run_len(1'b0, a);
    check("R5 bcd mode0 remaining low", a, 9);
    @(negedge clk);
    check("R4 bcd wrap", int'(count), 16'h9999);

    // R12 binary zero in mode 0
    cfg(3'd0, 1'b0);
    load(16'h0000);
    run_len(1'b0, a);
    check("R12 binary zero low length", a, 65537);
    @(negedge clk);
    check("R4 binary wrap", int'(count), 16'hFFFF);

    // R12 BCD zero in mode 2
    cfg(3'd2, 1'b1);
    load(16'h0000);
    @(negedge clk);
    run_len(1'b1, a);
    check("R12 bcd zero high length", a, 9999);
    run_len(1'b0, a);
    check("R7 bcd zero low length", a, 1);

    // R6 one-shot and retrigger
    gate = 1'b0;
    cfg(3'd1, 1'b0);
    load(16'd5);
    @(negedge clk);
    check("R6 waits for trigger", int'(out), 1);
    gate = 1'b1;
    @(negedge clk);
    run_len(1'b0, a);
    check("R6 pulse length", a, 5);
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; @(negedge clk);
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; @(negedge clk);
    run_len(1'b0, a);
    check("R6 retrigger low length", a, 5);

    // R10 gate-started strobe and retrigger
    gate = 1'b0;
    cfg(3'd5, 1'b0);
    load(16'd4);
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    run_len(1'b1, a);
    check("R10 high before strobe", a, 4);
    run_len(1'b0, a);
    check("R10 strobe width", a, 1);
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; @(negedge clk);
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; @(negedge clk);
    run_len(1'b1, a);
    check("R10 retrigger high length", a, 4);

    // R11 mode 2 gate low
    gate = 1'b1;
    cfg(3'd2, 1'b0);
    load(16'd6);
    repeat (4) @(negedge clk);
    gate = 1'b0;
    @(negedge clk);
    check("R11 rate out forced high", int'(out), 1);
    check("R11 rate count restarted", int'(count), 6);
    gate = 1'b1;
    run_len(1'b1, a);
    check("R11 rate full period after gate", a, 5);

    // R2 code 6 acts as rate generator
    cfg(3'd6, 1'b0);
    load(16'd4);
    @(negedge clk);
    run_len(1'b1, a);
    check("R2 code6 high", a, 3);
    run_len(1'b0, a);
    check("R2 code6 low", a, 1);

    // R8 mode 3 with N=3 and gate low
    cfg(3'd3, 1'b0);
    load(16'd3);
    @(negedge clk);
    run_len(1'b1, a);
    check("R8 odd high", a, 2);
    run_len(1'b0, a);
    check("R8 odd low", a, 1);
    gate = 1'b0;
    @(negedge clk);
    check("R11 square out forced high", int'(out), 1);
    gate = 1'b1;

    // random passes over modes 0, 2, 3, 4
    for (int it = 0; it < 16; it++) begin
      int m, n;
      logic b;
      logic [15:0] v;
      case ($urandom_range(3, 0))
        0: m = 0;
        1: m = 2;
        2: m = 3;
        default: m = 4;
      endcase
      b = 1'($urandom_range(1, 0));
      n = int'($urandom_range(200, 2));
      v = b ? to_bcd(n) : 16'(n);
      gate = 1'b1;
      cfg(3'(m), b);
      load(v);
      if (m == 0) begin
        run_len(1'b0, a);
        check("R5 mode0 low length", a, exp_lo(m, n));
      end else if (m == 4) begin
        @(negedge clk);
        run_len(1'b1, a);
        check("R9 high before strobe", a, exp_hi(m, n));
        run_len(1'b0, a);
        check("R9 strobe width", a, exp_lo(m, n));
        lows_in(n + 4, a);
        check("R9 single strobe", a, 0);
      end else begin
        @(negedge clk);
        run_len(1'b1, a);
        check(m == 2 ? "R7 high" : "R8 high", a, exp_hi(m, n));
        run_len(1'b0, a);
        check(m == 2 ? "R7 low" : "R8 low", a, exp_lo(m, n));
        run_len(1'b1, a);
        check(m == 2 ? "R7 second high" : "R8 second high", a, exp_hi(m, n));
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule